// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the master side of a single-device SPI link to a serial NOR flash. A local agent hands it one request at a time. The request can be an identity check, clearing the block-protect bits, a read of N bytes, programming one 256-byte page, erasing one erase unit, or erasing the whole device. The sequencer expands each request into the chip-select frames the flash expects: opcode, 24-bit address, payload, and any status polling. It uses SPI mode 0 with 8-bit frames and a parameterised SCK divider.

Write-type commands are always preceded by a one-byte write-enable frame. The sequencer does not wait after a program or erase. It remembers that the flash may still be busy, and the next read, program or erase starts by polling the status register until the write-in-progress bit is clear. A chip erase is the exception: it is polled to completion before the request is reported done. Program data enters on a byte stream, and read data leaves on a second byte stream. Both streams use valid/ready.

Top module: `nor_seq`

## Requirements
- R1: While `rst` is high and after it falls, `cs_n` is 1, `sck` is 0, and `busy`, `done` and `rd_valid` are 0.
- R2: `sck` is 0 whenever `cs_n` is 1. Each byte is shifted MSB first, with `mosi` changing while `sck` is low and `miso` sampled on the rising edge. `cs_n` stays high for at least one SCK period (2*HALF clocks) between frames.
- R3: `req_op`=0 (identify) sends 0x9F and clocks in three bytes. `id_fail` becomes 0 only if they are 0xBF, 0x25, 0x4B in that order, and 1 otherwise. It holds its value until the next identify completes.
- R4: `req_op`=1 (unprotect) sends one frame holding 0x50, then a second frame holding 0x01 and then 0x00.
- R5: `req_op`=2 (read) sends 0x03 and `req_addr` as three bytes, high byte first. It then delivers `req_len` bytes on `rd_data`/`rd_valid`, in address order. `rd_valid` and `rd_data` hold until `rd_ready`, and no further SCK edges occur while a byte waits.
- R6: `req_op`=3 (program) sends a write-enable frame (0x06) first. It then sends 0x02, the address `req_addr`<<8 (page number to byte address), and exactly 256 bytes taken from `wr_data` on each cycle where `wr_valid` and `wr_ready` are both high.
- R7: `req_op`=4 (erase unit) sends a write-enable frame, then a frame of 0x20 followed by the three address bytes of `req_addr`.
- R8: `req_op`=5 (chip erase) sends a write-enable frame, then a one-byte frame of 0xC7, then a full status poll. The request is done only after the poll sees the device idle.
- R9: A status poll is one frame. It sends 0x05 and then 0xA5 filler bytes, and it ends right after the first returned status byte whose bit 0 is 0.
- R10: A read, program or erase starts with a status poll exactly when a program or erase has been issued since the last completed poll. Otherwise its first frame is its own command.
- R11: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until completion, when `done` pulses for one cycle as `busy` falls. Codes 6 and 7 are ignored: no frame is sent and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request code (0 identify, 1 unprotect, 2 read, 3 program, 4 erase unit, 5 chip erase) |
| req_addr | input | 24 | Byte address; page number for program |
| req_len | input | LEN_W | Read length in bytes (at least 1) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| id_fail | output | 1 | Last identify did not match |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Sequencer takes `wr_data` this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Consumer accepts `rd_data` |
| sck | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
On every cycle, the assertions check these properties: SCK stays idle while chip select is high, the minimum deselect gap between frames, the single-cycle done pulse that ends busy, held read data under backpressure, and a stable `id_fail` between requests. The frame contents can only be shown by the bench scenarios against its flash model. These are the opcodes, address bytes, the 256-byte payload checksum, whether a poll is inserted or skipped after writes, how long a poll lasts against a device that stays busy for several status reads, and the pass or fail of the identity match.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [2:0] {
    OP_ID = 3'd0, OP_UNPROT = 3'd1, OP_READ = 3'd2,
    OP_PROG = 3'd3, OP_ERASE = 3'd4, OP_CHIP = 3'd5
  } req_op_e;

  typedef enum logic [3:0] {
    F_NONE, F_POLL, F_WREN, F_EWSR, F_WRSR, F_ID, F_READ, F_PROG, F_ERASE, F_CHIP
  } frame_e;

  localparam logic [7:0] C_WREN   = 8'h06;
  localparam logic [7:0] C_RDSR   = 8'h05;
  localparam logic [7:0] C_EWSR   = 8'h50;
  localparam logic [7:0] C_WRSR   = 8'h01;
  localparam logic [7:0] C_READ   = 8'h03;
  localparam logic [7:0] C_PROG   = 8'h02;
  localparam logic [7:0] C_SERASE = 8'h20;
  localparam logic [7:0] C_CHIP   = 8'hC7;
  localparam logic [7:0] C_RDID   = 8'h9F;
  localparam logic [7:0] C_FILL   = 8'hA5;
endpackage

// File: rtl/nor_spi_byte.sv
// One 8-bit SPI mode-0 transfer per start pulse; sck period = 2*HALF clocks.
module nor_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  output logic [7:0] rx,
  output logic       fin,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    nb;
  logic          act;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    fin <= 1'b0;
    if (rst) begin
      cnt <= '0; sh <= '0; nb <= '0; act <= 1'b0; sck <= 1'b0; rx <= '0;
    end else if (start) begin
      sh <= tx; cnt <= '0; nb <= '0; act <= 1'b1; sck <= 1'b0;
    end else if (act) begin
      if (cnt == CW'(HALF - 1)) begin
        cnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (nb == 3'd7) begin
            act <= 1'b0;
            fin <= 1'b1;
          end else begin
            nb <= nb + 3'd1;
            sh <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/nor_seq_ctrl.sv
// Frame sequencer: picks the frame order per request and the byte sent at each index.
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int          HALF       = 2,
  parameter int          LEN_W      = 16,
  parameter int          PAGE_BYTES = 256,
  parameter logic [23:0] ID_EXP     = 24'hBF254B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             id_fail,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             cs_n,
  output logic             b_start,
  output logic [7:0]       b_tx,
  input  logic [7:0]       b_rx,
  input  logic             b_fin
);
  localparam int BW         = LEN_W + 2;
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int GAP        = 2 * HALF;
  localparam int GW         = $clog2(GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP} st_e;

  st_e              st;
  frame_e           frm;
  req_op_e          op, rop;
  logic [23:0]      addr;
  logic [LEN_W-1:0] len;
  logic [BW-1:0]    bidx, flast;
  logic [15:0]      idsh;
  logic [GW-1:0]    gcnt;
  logic             last_wr, tail, data_phase, frame_end;
  logic [7:0]       txb;

  function automatic frame_e first_frame(req_op_e o, logic lw);
    case (o)
      OP_ID:                    return F_ID;
      OP_UNPROT:                return F_EWSR;
      OP_READ:                  return lw ? F_POLL : F_READ;
      OP_PROG, OP_ERASE, OP_CHIP: return lw ? F_POLL : F_WREN;
      default:                  return F_NONE;
    endcase
  endfunction

  function automatic frame_e next_frame(frame_e f, req_op_e o, logic t);
    case (f)
      F_POLL:  return t ? F_NONE : ((o == OP_READ) ? F_READ : F_WREN);
      F_WREN:  return (o == OP_PROG) ? F_PROG : ((o == OP_ERASE) ? F_ERASE : F_CHIP);
      F_EWSR:  return F_WRSR;
      F_CHIP:  return F_POLL;
      default: return F_NONE;
    endcase
  endfunction

  always_comb rop = req_op_e'(req_op);
  assign data_phase = (bidx >= BW'(4));
  assign wr_ready   = (st == S_LOAD) && (frm == F_PROG) && data_phase;

  always_comb begin
    case (frm)
      F_WRSR:  flast = BW'(1);
      F_ID:    flast = BW'(3);
      F_READ:  flast = BW'(3) + BW'(len);
      F_PROG:  flast = BW'(3 + PAGE_BYTES);
      F_ERASE: flast = BW'(3);
      default: flast = '0;
    endcase
    frame_end = (frm == F_POLL) ? (bidx != '0 && !b_rx[0]) : (bidx == flast);
  end

  always_comb begin
    case (frm)
      F_POLL:  txb = (bidx == '0) ? C_RDSR : C_FILL;
      F_WREN:  txb = C_WREN;
      F_EWSR:  txb = C_EWSR;
      F_CHIP:  txb = C_CHIP;
      F_WRSR:  txb = (bidx == '0) ? C_WRSR : 8'h00;
      F_ID:    txb = (bidx == '0) ? C_RDID : C_FILL;
      default: begin
        case (bidx)
          BW'(0):  txb = (frm == F_READ) ? C_READ : ((frm == F_PROG) ? C_PROG : C_SERASE);
          BW'(1):  txb = addr[23:16];
          BW'(2):  txb = addr[15:8];
          BW'(3):  txb = addr[7:0];
          default: txb = (frm == F_PROG) ? wr_data : C_FILL;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st <= S_IDLE; frm <= F_NONE; op <= OP_ID; addr <= '0; len <= '0;
      bidx <= '0; idsh <= '0; gcnt <= '0; last_wr <= 1'b0; tail <= 1'b0;
      busy <= 1'b0; id_fail <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      cs_n <= 1'b1; b_start <= 1'b0; b_tx <= '0;
    end else begin
      b_start <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && first_frame(rop, last_wr) != F_NONE) begin
          op   <= rop;
          addr <= (rop == OP_PROG) ? 24'(req_addr << PAGE_SHIFT) : req_addr;
          len  <= req_len;
          frm  <= first_frame(rop, last_wr);
          bidx <= '0;
          tail <= 1'b0;
          busy <= 1'b1;
          st   <= S_LOAD;
        end
        S_LOAD: if (!rd_valid && !(wr_ready && !wr_valid)) begin
          b_start <= 1'b1;
          b_tx    <= txb;
          cs_n    <= 1'b0;
          st      <= S_SHIFT;
        end
        S_SHIFT: if (b_fin) begin
          if (frm == F_ID && bidx != '0) idsh <= {idsh[7:0], b_rx};
          if (frm == F_READ && data_phase) begin
            rd_data  <= b_rx;
            rd_valid <= 1'b1;
          end
          if (frame_end) begin
            cs_n <= 1'b1;
            gcnt <= '0;
            bidx <= '0;
            frm  <= next_frame(frm, op, tail);
            st   <= S_GAP;
            case (frm)
              F_PROG, F_ERASE: last_wr <= 1'b1;
              F_CHIP:  begin last_wr <= 1'b1; tail <= 1'b1; end
              F_POLL:  last_wr <= 1'b0;
              F_ID:    id_fail <= ({idsh, b_rx} != ID_EXP);
              default: ;
            endcase
          end else begin
            bidx <= (frm == F_POLL) ? BW'(1) : bidx + BW'(1);
            st   <= S_LOAD;
          end
        end
        S_GAP: begin
          if (gcnt != GW'(GAP)) gcnt <= gcnt + GW'(1);
          else if (frm != F_NONE) st <= S_LOAD;
          else if (!rd_valid) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r6_wr_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (busy && !cs_n));
  a_r3_id_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> $stable(id_fail));
endmodule

// File: rtl/nor_seq.sv
module nor_seq #(
  parameter int          HALF       = 2,
  parameter int          LEN_W      = 16,
  parameter int          PAGE_BYTES = 256,
  parameter logic [23:0] ID_EXP     = 24'hBF254B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             id_fail,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int GAP = 2 * HALF;
  localparam int GW  = $clog2(GAP + 1);

  logic       b_start, b_fin;
  logic [7:0] b_tx, b_rx;

  nor_seq_ctrl #(.HALF(HALF), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .ID_EXP(ID_EXP)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .done(done), .id_fail(id_fail),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .cs_n(cs_n), .b_start(b_start), .b_tx(b_tx), .b_rx(b_rx), .b_fin(b_fin)
  );

  nor_spi_byte #(.HALF(HALF)) u_shift (
    .clk(clk), .rst(rst), .start(b_start), .tx(b_tx), .rx(b_rx), .fin(b_fin),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // cycles chip select has been high, saturating at GAP
  logic [GW-1:0] hicnt;
  always_ff @(posedge clk) begin
    if (rst) hicnt <= GW'(GAP);
    else if (!cs_n) hicnt <= '0;
    else if (hicnt != GW'(GAP)) hicnt <= hicnt + GW'(1);
  end

  a_r2_sck_idle: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck);
  a_r2_gap_min: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hicnt == GW'(GAP)));
endmodule

// File: tb/tb_nor_seq.sv
module tb_nor_seq;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;
  localparam int BUSYN = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic busy, done, id_fail, wr_ready, rd_valid, sck, cs_n, mosi, miso;
  logic [7:0] wr_data = '0, rd_data;
  logic wr_valid = 1'b0, rd_ready = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nor_seq #(.HALF(HALF)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .done(done), .id_fail(id_fail),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input int a);
    return 8'(a ^ (a >> 8) ^ 8'h3C);
  endfunction
  function automatic logic [7:0] wpat(input int i);
    return 8'(i * 37 + 11);
  endfunction

  // ---------------- flash model ----------------
  logic [7:0] id0 = 8'hBF, id1 = 8'h25, id2 = 8'h4B;
  logic [7:0] out_b = 8'hFF, inb = '0, fop_cur = '0, fd1 = '0;
  logic [23:0] faddr = '0;
  int bitc = 0, bytec = 0, wip_cnt = 0, fsum_cur = 0, nfr = 0, nbad = 0;
  bit wel = 0, have_up = 0;
  logic [7:0]  fop [64];
  int          flen[64];
  logic [23:0] fad [64];
  int          fsum[64];
  logic [7:0]  fdt [64];
  time tup = 0, mingap = 1000000;
  int sck_bad = 0;

  assign miso = out_b[3'(7 - bitc)];

  always @(negedge cs_n) begin
    bitc = 0; bytec = 0; fsum_cur = 0; faddr = '0; out_b = 8'hFF; fop_cur = '0;
    if (have_up && ($time - tup) < mingap) mingap = $time - tup;
  end

  always @(posedge cs_n) begin
    if (bytec > 0) begin
      fop[nfr%64] = fop_cur; flen[nfr%64] = bytec; fad[nfr%64] = faddr;
      fsum[nfr%64] = fsum_cur; fdt[nfr%64] = fd1;
      if (fop_cur == 8'h02 || fop_cur == 8'h20 || fop_cur == 8'hC7) begin
        if (!wel || wip_cnt != 0) nbad++;
        wip_cnt = BUSYN; wel = 0;
      end
      if (fop_cur == 8'h06) wel = 1;
      nfr++;
      tup = $time; have_up = 1;
    end
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      inb = {inb[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (bytec == 0) fop_cur = inb;
        else if (bytec <= 3) faddr = {faddr[15:0], inb};
        if (bytec == 1) fd1 = inb;
        if (fop_cur == 8'h02 && bytec >= 4) fsum_cur += int'(inb);
        out_b = 8'hFF;
        if (fop_cur == 8'h05) begin
          out_b = {6'b0, wel, (wip_cnt > 0)};
          if (wip_cnt > 0) wip_cnt--;
        end else if (fop_cur == 8'h9F) out_b = (bytec == 0) ? id0 : ((bytec == 1) ? id1 : id2);
        else if (fop_cur == 8'h03 && bytec >= 3) out_b = mem(int'(faddr) + bytec - 3);
        bytec++;
      end
    end
  end

  // ---------------- streams ----------------
  int widx = 0, rexp = 0, rcnt = 0, rbad = 0;
  initial forever begin
    @(negedge clk);
    if (cs_n && sck) sck_bad++;
    wr_valid = ($urandom % 4) != 0;
    wr_data  = wpat(widx);
    if (wr_valid && wr_ready) widx++;
    rd_ready = ($urandom % 3) != 0;
    if (rd_valid && rd_ready) begin
      if (rd_data !== mem(rexp + rcnt)) rbad++;
      rcnt++;
    end
  end

  task automatic do_req(input int o, input int a, input int l);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(o); req_addr = 24'(a); req_len = 16'(l);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
    t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    if (!done) chk(1'b0, "R11 done timeout", 0, 1);
    else chk(busy == 1'b0, "R11 busy low with done", int'(busy), 0);
    @(negedge clk);
  endtask

  task automatic expf(input int i, input int op, input string r);
    chk(fop[i%64] == 8'(op), r, int'(fop[i%64]), op);
  endtask

  task automatic do_read(input int a, input int l, input bit polled, input string r);
    int n0;
    n0 = nfr; rexp = a; rcnt = 0; rbad = 0;
    do_req(2, a, l);
    if (polled) begin
      expf(n0, 8'h05, "R10 read polls first");
      chk(flen[n0%64] == BUSYN + 2, "R9 poll length", flen[n0%64], BUSYN + 2);
      n0++;
    end else expf(n0, 8'h03, "R10 read without poll");
    chk(fad[n0%64] == 24'(a), "R5 read address", int'(fad[n0%64]), a);
    chk(flen[n0%64] == 4 + l, "R5 read frame length", flen[n0%64], 4 + l);
    chk(rcnt == l && rbad == 0, r, rcnt * 1000 + rbad, l * 1000);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int n0, p, a, w0, es;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0, "R1 in reset", {cs_n, sck, busy}, 3'b100);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0,
        "R1 after reset", {cs_n, sck, busy, done, rd_valid}, 5'b10000);

    // identify: match, mismatch, match again
    n0 = nfr; do_req(0, 0, 0);
    chk(id_fail == 1'b0, "R3 id match", int'(id_fail), 0);
    expf(n0, 8'h9F, "R3 id opcode");
    chk(flen[n0%64] == 4 && nfr == n0 + 1, "R3 id frame", flen[n0%64], 4);
    id1 = 8'h26; do_req(0, 0, 0);
    chk(id_fail == 1'b1, "R3 id mismatch", int'(id_fail), 1);
    repeat (20) @(negedge clk);
    chk(id_fail == 1'b1, "R3 id_fail held", int'(id_fail), 1);
    id1 = 8'h25; id2 = 8'h4A; do_req(0, 0, 0);
    chk(id_fail == 1'b1, "R3 capacity mismatch", int'(id_fail), 1);
    id2 = 8'h4B; do_req(0, 0, 0);
    chk(id_fail == 1'b0, "R3 id match again", int'(id_fail), 0);

    // ignored codes
    n0 = nfr;
    @(negedge clk); req_valid = 1'b1; req_op = 3'd6;
    @(negedge clk); req_op = 3'd7;
    @(negedge clk); req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && nfr == n0, "R11 codes 6/7 ignored", nfr - n0, 0);

    // unprotect
    n0 = nfr; do_req(1, 0, 0);
    chk(nfr == n0 + 2, "R4 two frames", nfr - n0, 2);
    expf(n0, 8'h50, "R4 first frame");
    chk(flen[n0%64] == 1, "R4 first frame length", flen[n0%64], 1);
    expf(n0 + 1, 8'h01, "R4 second frame");
    chk(flen[(n0+1)%64] == 2 && fdt[(n0+1)%64] == 8'h00, "R4 status value 0",
        int'(fdt[(n0+1)%64]), 0);

    // program with no pending write
    p = int'($urandom % 65536); w0 = widx; n0 = nfr; do_req(3, p, 0);
    expf(n0, 8'h06, "R6 write enable first (R10 no poll)");
    expf(n0 + 1, 8'h02, "R6 program opcode");
    chk(fad[(n0+1)%64] == 24'(p << 8), "R6 page address", int'(fad[(n0+1)%64]), p << 8);
    chk(flen[(n0+1)%64] == 260, "R6 256 data bytes", flen[(n0+1)%64], 260);
    es = 0; for (int k = 0; k < 256; k++) es += int'(wpat(w0 + k));
    chk(fsum[(n0+1)%64] == es && widx == w0 + 256, "R6 data stream", fsum[(n0+1)%64], es);

    // read after program polls, then again without poll
    do_read(int'($urandom % 24'hFFFFFF), 1 + int'($urandom % 40), 1'b1, "R5 read data after poll");
    chk(wip_cnt == 0, "R9 poll ran to idle", wip_cnt, 0);
    do_read(int'($urandom % 24'hFFFFFF), 1, 1'b0, "R5 single byte read");

    // erase unit then program (must poll first)
    a = int'($urandom % 24'hFFFFFF); n0 = nfr; do_req(4, a, 0);
    expf(n0, 8'h06, "R7 write enable");
    expf(n0 + 1, 8'h20, "R7 erase opcode");
    chk(fad[(n0+1)%64] == 24'(a) && flen[(n0+1)%64] == 4, "R7 erase address", int'(fad[(n0+1)%64]), a);
    n0 = nfr; do_req(3, 5, 0);
    expf(n0, 8'h05, "R10 program polls after erase");
    expf(n0 + 1, 8'h06, "R6 enable after poll");
    expf(n0 + 2, 8'h02, "R6 program after poll");

    // chip erase
    n0 = nfr; do_req(5, 0, 0);
    chk(nfr == n0 + 4, "R8 frame count", nfr - n0, 4);
    expf(n0, 8'h05, "R10 poll before chip erase");
    expf(n0 + 1, 8'h06, "R8 write enable");
    expf(n0 + 2, 8'hC7, "R8 chip opcode");
    chk(flen[(n0+2)%64] == 1, "R8 chip frame length", flen[(n0+2)%64], 1);
    expf(n0 + 3, 8'h05, "R8 final poll");
    chk(wip_cnt == 0 && flen[(n0+3)%64] == BUSYN + 2, "R8 done after idle", wip_cnt, 0);
    do_read(100, 8, 1'b0, "R10 read after chip erase skips poll");

    // random reads under backpressure
    for (int i = 0; i < 6; i++)
      do_read(int'($urandom % 24'hFFFFFF), 1 + int'($urandom % 24), 1'b0, "R5 random read data");

    chk(nbad == 0, "R10 no write issued while busy or unenabled", nbad, 0);
    chk(sck_bad == 0, "R2 sck idle with cs high", sck_bad, 0);
    chk(mingap >= time'(2 * HALF * CLK_P), "R2 deselect gap", int'(mingap), 2 * HALF * CLK_P);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule